// File: doc/BRIEF.md
# Parallel ADC Readout Controller

This block sits on the host side of a 12-bit successive-approximation converter that has a parallel result bus and two active-low control strobes: a chip-select and a read/convert line. A one-cycle start request makes the controller launch a conversion with a read/convert falling edge. It then follows the converter's busy handshake through its fall and its return high, and reads the finished code off the bus.

Two read styles are supported. In word mode one read takes all twelve bits from the upper bits of a 16-bit bus. In byte mode two reads are made on an 8-bit bus, steered by a byte-select output: first the upper eight result bits, then the lower four result bits followed by four zero pad bits. Each finished conversion produces a 12-bit word and a one-cycle valid pulse. A missing busy response ends the attempt with a timeout pulse and returns both strobes to their idle level. The busy input is synchronised before it steers any decision. The bus is sampled only after a settle count while the output is enabled.

Top module: `adc_par_rd_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `cs_n_o` and `rc_n_o` are high, and `byte_sel_o`, `valid_o`, `timeout_o` and `frame_err_o` are low.
- R2: Each accepted start produces exactly one conversion edge. `rc_n_o` falls only while `cs_n_o` is low, and `cs_n_o` never falls while `rc_n_o` is low.
- R3: A start is accepted only when the controller is idle and the synchronised busy is high. A start that arrives during a conversion or readout, or while busy is low, causes no strobe activity.
- R4: After the conversion edge, the controller lowers `cs_n_o` for a read only after busy has fallen and then returned high.
- R5: In word mode (`byte_mode_i` = 0 at start), the result is `bus_i[15:4]`, with bit 15 as the MSB. It is presented on `result_o` together with a single-cycle `valid_o`.
- R6: In byte mode (`byte_mode_i` = 1 at start), the first read has `byte_sel_o` low and the second has it high. `byte_sel_o` changes only while `cs_n_o` is high. The result is {first `bus_i[15:8]`, second `bus_i[15:12]`}.
- R7: In byte mode, when the second read has a nonzero `bus_i[11:8]`, `frame_err_o` pulses in the same cycle as `valid_o`. The assembled word is still delivered.
- R8: Each read samples the bus only after SETTLE cycles with `cs_n_o` low and `rc_n_o` high, and `cs_n_o` returns high after every read.
- R9: If synchronised busy has not fallen within FALL_TO cycles after the conversion edge, `timeout_o` pulses, `valid_o` stays low and both strobes are high.
- R10: If synchronised busy has not risen within RISE_TO cycles after it fell, `timeout_o` pulses, `valid_o` stays low and both strobes are high. The next start then works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, one cycle |
| byte_mode_i | input | 1 | 1 selects two byte reads, 0 selects one word read; latched at start |
| busy_i | input | 1 | Converter busy handshake, low while converting (asynchronous) |
| bus_i | input | 16 | Converter data bus; result in the upper bits |
| cs_n_o | output | 1 | Active-low chip-select |
| rc_n_o | output | 1 | Read/convert strobe: low converts, high reads |
| byte_sel_o | output | 1 | Byte steering: 0 selects the upper byte, 1 the lower |
| result_o | output | 12 | Assembled conversion result |
| valid_o | output | 1 | One-cycle pulse marking `result_o` |
| frame_err_o | output | 1 | Nonzero pad bits seen in the low-byte read |
| timeout_o | output | 1 | Busy handshake missing, attempt aborted |

## Verification
A wrong state in the sequencer shows at the strobes within one cycle. An out-of-order step lowers chip-select while read/convert is low, which starts a spurious conversion, or it reads while busy is still low. Either of these is counted by the bus model in the bench at the edge where it happens. A wrong settle count or a wrong phase shows as a corrupted result on the next valid pulse, because the modelled bus carries junk during its first enabled cycles. A stuck wait state shows as a missing valid or a missing timeout within the limit windows.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_STRB,
    ST_WFALL,
    ST_WRISE,
    ST_RD,
    ST_GAP
  } rd_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/adc_busy_sync.sv
module adc_busy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/adc_wait_timer.sv
module adc_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr_i)    cnt_o <= '0;
    else if (cnt_o != TOP) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/adc_word_assembler.sv
module adc_word_assembler #(
  parameter int RES_W  = 12,
  parameter int BUS_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_hi_i,
  input  logic             byte_mode_i,
  input  logic [BUS_W-1:0] bus_i,
  output logic [RES_W-1:0] word_o,
  output logic             frame_err_o
);
  localparam int LO_KEEP = RES_W - BYTE_W;
  localparam int LO_PAD  = BYTE_W - LO_KEEP;

  logic [BYTE_W-1:0] hi_q;
  logic [BYTE_W-1:0] lane;

  assign lane = bus_i[BUS_W-1 -: BYTE_W];

  always_ff @(posedge clk) begin
    if (rst)            hi_q <= '0;
    else if (load_hi_i) hi_q <= lane;
  end

  always_comb begin
    if (byte_mode_i) begin
      word_o      = {hi_q, lane[BYTE_W-1 -: LO_KEEP]};
      frame_err_o = |lane[LO_PAD-1:0];
    end else begin
      word_o      = bus_i[BUS_W-1 -: RES_W];
      frame_err_o = 1'b0;
    end
  end
endmodule

// File: rtl/adc_par_rd_ctrl.sv
module adc_par_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int BUS_W       = 16,
  parameter int BYTE_W      = 8,
  parameter int SETTLE      = 3,
  parameter int FALL_TO     = 8,
  parameter int RISE_TO     = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             byte_mode_i,
  input  logic             busy_i,
  input  logic [BUS_W-1:0] bus_i,
  output logic             cs_n_o,
  output logic             rc_n_o,
  output logic             byte_sel_o,
  output logic [RES_W-1:0] result_o,
  output logic             valid_o,
  output logic             frame_err_o,
  output logic             timeout_o
);
  localparam int CNT_W = $clog2(max3(SETTLE, FALL_TO, RISE_TO) + 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE - 1);
  localparam logic [CNT_W-1:0] FALL_LAST   = CNT_W'(FALL_TO - 1);
  localparam logic [CNT_W-1:0] RISE_LAST   = CNT_W'(RISE_TO - 1);

  rd_state_e        state_q, state_d;
  logic             phase_q, phase_d;
  logic             mode_q, mode_d;
  logic             busy_s;
  logic [CNT_W-1:0] cnt;
  logic             load_hi, fin, to_d;
  logic [RES_W-1:0] word;
  logic             ferr;

  adc_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(busy_i), .q_o(busy_s)
  );

  adc_wait_timer #(.W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .clr_i(state_d != state_q), .cnt_o(cnt)
  );

  adc_word_assembler #(.RES_W(RES_W), .BUS_W(BUS_W), .BYTE_W(BYTE_W)) u_asm (
    .clk(clk), .rst(rst), .load_hi_i(load_hi), .byte_mode_i(mode_q),
    .bus_i(bus_i), .word_o(word), .frame_err_o(ferr)
  );

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    mode_d  = mode_q;
    load_hi = 1'b0;
    fin     = 1'b0;
    to_d    = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i && busy_s) begin
        state_d = ST_SEL;
        phase_d = 1'b0;
        mode_d  = byte_mode_i;
      end
      ST_SEL:  state_d = ST_STRB;
      ST_STRB: state_d = ST_WFALL;
      ST_WFALL: begin
        if (!busy_s) state_d = ST_WRISE;
        else if (cnt == FALL_LAST) begin
          state_d = ST_IDLE;
          to_d    = 1'b1;
        end
      end
      ST_WRISE: begin
        if (busy_s) state_d = ST_RD;
        else if (cnt == RISE_LAST) begin
          state_d = ST_IDLE;
          to_d    = 1'b1;
        end
      end
      ST_RD: if (cnt == SETTLE_LAST) begin
        if (mode_q && !phase_q) begin
          load_hi = 1'b1;
          phase_d = 1'b1;
          state_d = ST_GAP;
        end else begin
          fin     = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_GAP:  state_d = ST_RD;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      phase_q     <= 1'b0;
      mode_q      <= 1'b0;
      cs_n_o      <= 1'b1;
      rc_n_o      <= 1'b1;
      byte_sel_o  <= 1'b0;
      result_o    <= '0;
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
      timeout_o   <= 1'b0;
    end else begin
      state_q     <= state_d;
      phase_q     <= phase_d;
      mode_q      <= mode_d;
      cs_n_o      <= !(state_d == ST_SEL || state_d == ST_STRB || state_d == ST_RD);
      rc_n_o      <= !(state_d == ST_STRB || state_d == ST_WFALL);
      byte_sel_o  <= (state_d == ST_RD || state_d == ST_GAP) && phase_d;
      valid_o     <= fin;
      frame_err_o <= fin && ferr;
      timeout_o   <= to_d;
      if (fin) result_o <= word;
    end
  end
endmodule

// File: rtl/adc_par_rd_ctrl_chk.sv
module adc_par_rd_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic cs_n_o,
  input logic rc_n_o,
  input logic byte_sel_o,
  input logic valid_o,
  input logic frame_err_o,
  input logic timeout_o
);
  AST_CONV_EDGE_CS_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(rc_n_o) |-> !cs_n_o); // R2
  AST_NO_CS_FALL_IN_CONV: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> rc_n_o); // R2
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o); // R5
  AST_BSEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cs_n_o |-> $stable(byte_sel_o)); // R6
  AST_FERR_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |-> valid_o); // R7
  AST_CS_RELEASED: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> cs_n_o); // R8
  AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> (cs_n_o && rc_n_o && !valid_o)); // R9
endmodule

bind adc_par_rd_ctrl adc_par_rd_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cs_n_o(cs_n_o), .rc_n_o(rc_n_o),
  .byte_sel_o(byte_sel_o), .valid_o(valid_o),
  .frame_err_o(frame_err_o), .timeout_o(timeout_o)
);

// File: tb/adc_par_rd_ctrl_tb.sv
module adc_par_rd_ctrl_tb;
  localparam int CONV = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        start = 1'b0, byte_mode = 1'b0, hold_low = 1'b0;
  logic        busy_m = 1'b1;
  logic [15:0] bus;
  logic        cs_n, rc_n, bsel, valid, ferr, tout;
  logic [11:0] result;

  int n_chk = 0, n_fail = 0;

  // converter model state
  int lat = 0, rem = 0, starts = 0, ord_viol = 0, rd_viol = 0, en_cnt = 0;
  bit no_fall = 0, no_rise = 0;
  logic [11:0] code_q = '0, next_code = '0;
  logic [3:0]  lo_junk = '0;
  logic prev_cs = 1'b1, prev_rc = 1'b1;
  logic en;

  assign en = !cs_n && rc_n;
  assign bus = !en ? 16'hzzzz :
               (en_cnt < 2) ? 16'hA5A5 :
               byte_mode ? (bsel ? {code_q[3:0], lo_junk, 8'h00} : {code_q[11:4], 8'h00})
                         : {code_q, 4'h0};

  always @(posedge clk) begin
    prev_cs <= cs_n;
    prev_rc <= rc_n;
    en_cnt  <= en ? en_cnt + 1 : 0;
    if (!rst && prev_cs && !cs_n && !rc_n) ord_viol <= ord_viol + 1;
    if (!rst && en && !busy_m) rd_viol <= rd_viol + 1;
    if (!rst && (prev_cs || prev_rc) && !(cs_n || rc_n) && busy_m && lat == 0 && rem == 0) begin
      starts <= starts + 1;
      if (!no_fall) lat <= 2;
    end
    if (lat > 0) begin
      if (lat == 1) begin busy_m <= 1'b0; rem <= CONV; end
      lat <= lat - 1;
    end else if (rem > 0 && !no_rise) begin
      if (rem == 1) begin busy_m <= 1'b1; code_q <= next_code; end
      rem <= rem - 1;
    end
  end

  adc_par_rd_ctrl u_dut (
    .clk(clk), .rst(rst), .start_i(start), .byte_mode_i(byte_mode),
    .busy_i(busy_m && !hold_low), .bus_i(bus), .cs_n_o(cs_n), .rc_n_o(rc_n),
    .byte_sel_o(bsel), .result_o(result), .valid_o(valid),
    .frame_err_o(ferr), .timeout_o(tout)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(output bit gv, output bit gt, output bit gf,
                           output logic [11:0] r, output bit saw_b, output bit cs_rel);
    gv = 0; gt = 0; gf = 0; r = '0; saw_b = 0; cs_rel = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (bsel && !cs_n) saw_b = 1;
      if (valid || tout) begin
        gv = valid; gt = tout; gf = ferr; r = result; cs_rel = cs_n && rc_n;
        break;
      end
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(cs_n && rc_n, "R1", "strobes high in reset", {cs_n, rc_n}, 2'b11);
    chk(!bsel && !valid && !tout && !ferr, "R1", "flags low in reset",
        {bsel, valid, tout, ferr}, 0);
    @(negedge clk) rst = 1'b0;
    chk(cs_n && rc_n && !valid, "R1", "idle after reset", {cs_n, rc_n, valid}, 3'b110);
    repeat (5) @(negedge clk);
  endtask

  task automatic t_read(input bit bm, input logic [11:0] code);
    bit gv, gt, gf, sb, cr; logic [11:0] r; int s0, ov0, rv0;
    byte_mode = bm; next_code = code; s0 = starts; ov0 = ord_viol; rv0 = rd_viol;
    pulse_start();
    wait_done(gv, gt, gf, r, sb, cr);
    chk(gv && !gt, bm ? "R6" : "R5", "valid seen", {gv, gt}, 2'b10);
    chk(r == code, bm ? "R6" : "R5", "result", r, code);
    chk(!gf, "R7", "no frame error on clean pad", gf, 0);
    chk(cr, "R8", "chip-select released at valid", cr, 1);
    if (bm) chk(sb, "R6", "second read used byte select high", sb, 1);
    @(negedge clk);
    chk(!valid, "R5", "valid single cycle", valid, 0);
    chk(starts == s0 + 1, "R2", "one conversion per start", starts - s0, 1);
    chk(ord_viol == ov0, "R2", "no chip-select fall during convert", ord_viol - ov0, 0);
    chk(rd_viol == rv0, "R4", "no read while busy low", rd_viol - rv0, 0);
    byte_mode = 1'b0;
  endtask

  task automatic t_frame();
    bit gv, gt, gf, sb, cr; logic [11:0] r;
    byte_mode = 1'b1; lo_junk = 4'h6; next_code = 12'h9C3;
    pulse_start();
    wait_done(gv, gt, gf, r, sb, cr);
    chk(gv && gf, "R7", "frame error with valid", {gv, gf}, 2'b11);
    chk(r == 12'h9C3, "R7", "word still delivered", r, 12'h9C3);
    lo_junk = 4'h0; byte_mode = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_ignore();
    bit gv, gt, gf, sb, cr; logic [11:0] r; int s0, extra;
    s0 = starts; next_code = 12'h3E1; extra = 0;
    pulse_start();
    repeat (10) @(negedge clk);
    pulse_start();
    wait_done(gv, gt, gf, r, sb, cr);
    chk(gv && r == 12'h3E1, "R3", "first request completes", r, 12'h3E1);
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (valid || !cs_n) extra++;
    end
    chk(extra == 0, "R3", "mid-flight start ignored", extra, 0);
    chk(starts == s0 + 1, "R3", "single conversion", starts - s0, 1);
  endtask

  task automatic t_busy_gate();
    int act; act = 0;
    hold_low = 1'b1;
    repeat (4) @(negedge clk);
    pulse_start();
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!cs_n || !rc_n) act++;
    end
    chk(act == 0, "R3", "start ignored while busy low", act, 0);
    hold_low = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_timeout(input bit rise_case);
    bit gv, gt, gf, sb, cr; logic [11:0] r;
    string req; req = rise_case ? "R10" : "R9";
    if (rise_case) no_rise = 1; else no_fall = 1;
    pulse_start();
    wait_done(gv, gt, gf, r, sb, cr);
    chk(gt && !gv, req, "timeout without valid", {gt, gv}, 2'b10);
    chk(cr, req, "strobes high at timeout", cr, 1);
    no_fall = 0; no_rise = 0;
    repeat (40) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_read(1'b0, 12'hABC);
    t_read(1'b0, 12'h001);
    t_read(1'b0, 12'hFFF);
    t_read(1'b1, 12'h5A7);
    t_read(1'b1, 12'h800);
    t_frame();
    t_ignore();
    t_busy_gate();
    t_timeout(1'b0);
    t_timeout(1'b1);
    t_read(1'b0, 12'h27D); // R10 recovery after timeout
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule